// File: doc/BRIEF.md
# Host Control Register Block

This block is the register window a host processor uses to drive a network controller. Transfers arrive on a byte-addressed register bus with separate read and write strobes. A write strobe updates one register on the next rising clock edge. Read data is combinational from the current register state and is valid while the read strobe is high.

The block keeps an interrupt mask, a 32-bit general pointer and a management-interface control word. It decodes command writes into a command-unit opcode and a receive-unit opcode, and issues them to the units that carry them out. It gathers completion events from those units into a status byte that software clears by writing ones, and it raises an interrupt line while any status bit is pending and interrupts are not masked.

Management-register accesses start PHY transfers. A write carrying the write opcode fires a one-cycle write trigger. A read made while the stored opcode is "read" fetches the PHY value into the data field. The serial management bus itself sits outside this block.

Top module: `ctl_regblock`

## Requirements
- R1: After a synchronous reset, the status byte, the interrupt mask, the general pointer and every trigger output are zero, so `irq` is low. The management word resets to zero except its ready bit (bit 28).
- R2: A read of offset 0x02 returns the status byte in bits 15:8. Bits 31:16 and 7:0 read as zero. Status bits 3:0 are always zero.
- R3: A write to offset 0x02 clears each status bit whose matching bit in `bus_wdata[15:8]` is 1. Bits written as 0 keep their value.
- R4: `stat_event[i]` sets status bit i+4 on the next edge. Events map as follows: bit 7 = command complete, bit 6 = frame received, bit 5 = command unit went inactive, bit 4 = receiver not ready. An event that arrives in the same cycle as a clearing write leaves its bit set.
- R5: Offset 0x00 is write-only and reads as zero. Only bit 0 of the written value is kept, as the interrupt mask. `irq` is high exactly when a status bit is set and the mask is 0.
- R6: A write to offset 0x01 takes the command-unit opcode from `bus_wdata[7:4]` and the receive-unit opcode from `bus_wdata[2:0]`. A nonzero command-unit opcode pulses `cu_go` for one cycle, in the cycle after the write. A nonzero receive-unit opcode pulses `ru_go` one cycle later than that. An opcode of zero (no-op) produces no pulse.
- R7: Offset 0x04 is the general pointer. It can be read and written over the bus, and its value is driven on `gptr`.
- R8: The management word at offset 0x10 has these fields: data in bits 15:0, register number in 20:16, PHY address in 25:21, opcode in 27:26 (01 = write, 10 = read), and ready in bit 28. A write whose opcode is 01 pulses `mgmt_wr_go` in the next cycle, with the written fields on the `mgmt_*` outputs. A write with any other opcode gives no pulse.
- R9: A read of offset 0x10 made while the stored opcode is 10 does three things. It raises `mgmt_rd_go` during the read, returns `phy_rdata` in bits 15:0, and stores that value in the data field. Every read of 0x10 returns bit 28 set.
- R10: Reads of offsets other than 0x00, 0x01, 0x02, 0x04 and 0x10 return zero. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| stat_event | input | 4 | One-cycle status events, bit i sets status bit i+4 |
| irq | output | 1 | Interrupt request |
| gptr | output | 32 | General pointer, operand for start/load commands |
| cu_go | output | 1 | Command-unit opcode valid pulse |
| cu_op | output | 4 | Command-unit opcode |
| ru_go | output | 1 | Receive-unit opcode valid pulse |
| ru_op | output | 3 | Receive-unit opcode |
| mgmt_phy | output | 5 | PHY address from the management word |
| mgmt_reg | output | 5 | PHY register number from the management word |
| mgmt_wdata | output | 16 | Data field of the management word |
| mgmt_wr_go | output | 1 | PHY register write trigger |
| mgmt_rd_go | output | 1 | PHY register read trigger, during a qualifying read |
| phy_rdata | input | 16 | PHY register value for management reads |

## Verification
The status path is driven from a vector table that steps through several cases: single events, events with the mask set, clear masks that touch only the always-zero low bits, a clear that hits a pending bit in the same cycle as that bit's event, and partial clears of a fully set byte. Together these separate a correct write-one-to-clear from write-to-set, from whole-byte clears, and from a clear that wins over a new event. Command writes use three cases: both opcodes nonzero, only the command-unit field nonzero, and only the receive-unit field nonzero. These expose swapped fields, missing no-op filtering and wrong issue order. Management accesses with the write, read and idle opcodes separate the two triggers from each other, and an access to an unlisted offset confirms that no register moves.

// File: rtl/regblk_pkg.sv
package regblk_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int STAT_W   = 8;
    localparam int EV_W     = 4;
    localparam int EV_LSB   = STAT_W - EV_W;
    localparam int CU_W     = 4;
    localparam int CU_LSB   = 4;
    localparam int RU_W     = 3;
    localparam int RU_LSB   = 0;
    localparam int MG_DW    = 16;

    localparam int OFS_IC   = 'h00;
    localparam int OFS_CMD  = 'h01;
    localparam int OFS_STAT = 'h02;
    localparam int OFS_GPTR = 'h04;
    localparam int OFS_MGMT = 'h10;

    typedef enum logic [1:0] {
        MG_IDLE  = 2'b00,
        MG_WRITE = 2'b01,
        MG_READ  = 2'b10,
        MG_RSVD  = 2'b11
    } mg_op_e;

    typedef struct packed {
        logic [2:0]       spare;
        logic             ready;
        mg_op_e           op;
        logic [4:0]       phy;
        logic [4:0]       regno;
        logic [MG_DW-1:0] data;
    } mgmt_t;

    function automatic logic [EV_W-1:0] stat_update(
        input logic [EV_W-1:0] cur,
        input logic [EV_W-1:0] clr,
        input logic [EV_W-1:0] ev
    );
        return (cur & ~clr) | ev;
    endfunction

endpackage

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
    import regblk_pkg::*;
#(
    parameter int CW = CU_W,
    parameter int RW = RU_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_wr,
    input  logic [CW-1:0] cu_field,
    input  logic [RW-1:0] ru_field,
    output logic          cu_go,
    output logic [CW-1:0] cu_op,
    output logic          ru_go,
    output logic [RW-1:0] ru_op
);
    logic          ru_pend;
    logic [RW-1:0] ru_pend_op;

    always_ff @(posedge clk) begin
        if (rst) begin
            cu_go      <= 1'b0;
            cu_op      <= '0;
            ru_pend    <= 1'b0;
            ru_pend_op <= '0;
            ru_go      <= 1'b0;
            ru_op      <= '0;
        end else begin
            cu_go   <= cmd_wr && (cu_field != '0);
            ru_pend <= cmd_wr && (ru_field != '0);
            if (cmd_wr) begin
                cu_op      <= cu_field;
                ru_pend_op <= ru_field;
            end
            ru_go <= ru_pend;
            ru_op <= ru_pend_op;
        end
    end
endmodule

// File: rtl/stat_collect.sv
module stat_collect
    import regblk_pkg::*;
#(
    parameter int EW = EV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_en,
    input  logic [EW-1:0] clr_bits,
    input  logic [EW-1:0] events,
    output logic [EW-1:0] pending
);
    logic [EW-1:0] clr_eff;

    assign clr_eff = clr_en ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= stat_update(pending, clr_eff, events);
    end
endmodule

// File: rtl/mgmt_ctl.sv
module mgmt_ctl
    import regblk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MG_DW-1:0]  phy_rdata,
    output logic [DATA_W-1:0] rd_val,
    output logic              wr_go,
    output logic              rd_go,
    output logic [4:0]        phy,
    output logic [4:0]        regno,
    output logic [MG_DW-1:0]  data
);
    mgmt_t ctl_q;
    mgmt_t wr_word;
    mgmt_t view;

    always_comb begin
        wr_word       = mgmt_t'(wdata);
        wr_word.ready = 1'b1;
    end

    assign rd_go = rd_en && (ctl_q.op == MG_READ);

    always_comb begin
        view = ctl_q;
        if (ctl_q.op == MG_READ) view.data = phy_rdata;
    end

    assign rd_val = DATA_W'(view);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q       <= '0;
            ctl_q.ready <= 1'b1;
            wr_go       <= 1'b0;
        end else begin
            wr_go <= wr_en && (wr_word.op == MG_WRITE);
            if (wr_en)      ctl_q      <= wr_word;
            else if (rd_go) ctl_q.data <= phy_rdata;
        end
    end

    assign phy   = ctl_q.phy;
    assign regno = ctl_q.regno;
    assign data  = ctl_q.data;
endmodule

// File: rtl/ctl_regblock.sv
module ctl_regblock
    import regblk_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [EV_W-1:0]   stat_event,
    output logic              irq,
    output logic [DATA_W-1:0] gptr,
    output logic              cu_go,
    output logic [CU_W-1:0]   cu_op,
    output logic              ru_go,
    output logic [RU_W-1:0]   ru_op,
    output logic [4:0]        mgmt_phy,
    output logic [4:0]        mgmt_reg,
    output logic [MG_DW-1:0]  mgmt_wdata,
    output logic              mgmt_wr_go,
    output logic              mgmt_rd_go,
    input  logic [MG_DW-1:0]  phy_rdata
);
    localparam logic [AW-1:0] A_IC   = AW'(OFS_IC);
    localparam logic [AW-1:0] A_CMD  = AW'(OFS_CMD);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
    localparam logic [AW-1:0] A_GPTR = AW'(OFS_GPTR);
    localparam logic [AW-1:0] A_MGMT = AW'(OFS_MGMT);

    logic              mask_q;
    logic [DATA_W-1:0] gptr_q;
    logic [EV_W-1:0]   status_hi;
    logic [DATA_W-1:0] mgmt_rd_val;
    logic [STAT_W-1:0] status_byte;

    logic sel_ic, sel_cmd, sel_stat, sel_gptr, sel_mgmt;

    assign sel_ic   = (bus_addr == A_IC);
    assign sel_cmd  = (bus_addr == A_CMD);
    assign sel_stat = (bus_addr == A_STAT);
    assign sel_gptr = (bus_addr == A_GPTR);
    assign sel_mgmt = (bus_addr == A_MGMT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= 1'b0;
            gptr_q <= '0;
        end else if (bus_wr) begin
            if (sel_ic)   mask_q <= bus_wdata[0];
            if (sel_gptr) gptr_q <= bus_wdata;
        end
    end

    cmd_dispatch #(.CW(CU_W), .RW(RU_W)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (bus_wr && sel_cmd),
        .cu_field (bus_wdata[CU_LSB +: CU_W]),
        .ru_field (bus_wdata[RU_LSB +: RU_W]),
        .cu_go    (cu_go),
        .cu_op    (cu_op),
        .ru_go    (ru_go),
        .ru_op    (ru_op)
    );

    stat_collect #(.EW(EV_W)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (bus_wr && sel_stat),
        .clr_bits (bus_wdata[STAT_W + EV_LSB +: EV_W]),
        .events   (stat_event),
        .pending  (status_hi)
    );

    mgmt_ctl u_mgmt (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr && sel_mgmt),
        .rd_en     (bus_rd && sel_mgmt),
        .wdata     (bus_wdata),
        .phy_rdata (phy_rdata),
        .rd_val    (mgmt_rd_val),
        .wr_go     (mgmt_wr_go),
        .rd_go     (mgmt_rd_go),
        .phy       (mgmt_phy),
        .regno     (mgmt_reg),
        .data      (mgmt_wdata)
    );

    assign status_byte = {status_hi, {EV_LSB{1'b0}}};

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_stat)      bus_rdata = DATA_W'({status_byte, {STAT_W{1'b0}}});
            else if (sel_gptr) bus_rdata = gptr_q;
            else if (sel_mgmt) bus_rdata = mgmt_rd_val;
        end
    end

    assign irq  = (status_hi != '0) && !mask_q;
    assign gptr = gptr_q;
endmodule

// File: rtl/ctl_regblock_chk.sv
module ctl_regblock_chk
    import regblk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [EV_W-1:0]   stat_event,
    input logic [EV_W-1:0]   status_hi,
    input logic              irq,
    input logic              cu_go,
    input logic [CU_W-1:0]   cu_op,
    input logic              ru_go,
    input logic [RU_W-1:0]   ru_op,
    input logic              mgmt_wr_go
);
    logic known;
    assign known = (bus_addr == ADDR_W'(OFS_STAT)) || (bus_addr == ADDR_W'(OFS_GPTR)) ||
                   (bus_addr == ADDR_W'(OFS_MGMT));

    a_r2_status_lanes: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OFS_STAT)) |->
            (bus_rdata[31:16] == '0 && bus_rdata[11:0] == '0));

    a_r3_clear_hits: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_STAT) && stat_event == '0) |=>
            ((status_hi & $past(bus_wdata[15:12])) == '0));

    a_r4_event_kept: assert property (@(posedge clk) disable iff (rst)
        (stat_event != '0) |=> ((status_hi & $past(stat_event)) == $past(stat_event)));

    a_r5_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_IC) && bus_wdata[0]) |=> !irq);

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (status_hi == '0) |-> !irq);

    a_r6_cu_issue: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_CMD) && bus_wdata[7:4] != '0) |=>
            (cu_go && cu_op == $past(bus_wdata[7:4])));

    a_r6_ru_issue: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_CMD) && bus_wdata[2:0] != '0) |=>
            ##1 (ru_go && ru_op == $past(bus_wdata[2:0], 2)));

    a_r8_wr_trigger: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_MGMT) && bus_wdata[27:26] == 2'b01) |=> mgmt_wr_go);

    a_r9_ready_bit: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OFS_MGMT)) |-> bus_rdata[28]);

    a_r10_unknown_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !known) |-> (bus_rdata == '0));
endmodule

bind ctl_regblock ctl_regblock_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .stat_event (stat_event),
    .status_hi  (status_hi),
    .irq        (irq),
    .cu_go      (cu_go),
    .cu_op      (cu_op),
    .ru_go      (ru_go),
    .ru_op      (ru_op),
    .mgmt_wr_go (mgmt_wr_go)
);

// File: tb/ctl_regblock_bench.sv
module ctl_regblock_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  stat_event = '0;
    logic        irq;
    logic [31:0] gptr;
    logic        cu_go;
    logic [3:0]  cu_op;
    logic        ru_go;
    logic [2:0]  ru_op;
    logic [4:0]  mgmt_phy;
    logic [4:0]  mgmt_reg;
    logic [15:0] mgmt_wdata;
    logic        mgmt_wr_go;
    logic        mgmt_rd_go;
    logic [15:0] phy_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ctl_regblock u_ctl_regblock (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat_event(stat_event), .irq(irq),
        .gptr(gptr), .cu_go(cu_go), .cu_op(cu_op), .ru_go(ru_go), .ru_op(ru_op),
        .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata),
        .mgmt_wr_go(mgmt_wr_go), .mgmt_rd_go(mgmt_rd_go), .phy_rdata(phy_rdata)
    );

    // {mask, events[3:0], clear[7:0], expected status[7:0], expected irq}
    localparam int NVEC = 10;
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 4'b1000, 8'h00, 8'h80, 1'b1},
        {1'b1, 4'b0000, 8'h00, 8'h80, 1'b0},
        {1'b0, 4'b0100, 8'h80, 8'h40, 1'b1},
        {1'b0, 4'b0011, 8'h00, 8'h70, 1'b1},
        {1'b0, 4'b0000, 8'h0F, 8'h70, 1'b1},
        {1'b0, 4'b0100, 8'h40, 8'h70, 1'b1},
        {1'b0, 4'b0000, 8'hFF, 8'h00, 1'b0},
        {1'b1, 4'b1111, 8'hF0, 8'hF0, 1'b0},
        {1'b0, 4'b0000, 8'hA0, 8'h50, 1'b1},
        {1'b0, 4'b0000, 8'h50, 8'h00, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic read_open(input logic [7:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2;
    endtask

    task automatic read_close();
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 gptr after reset", gptr, 32'h0);
        chk("R1 triggers after reset", {28'b0, cu_go, ru_go, mgmt_wr_go, mgmt_rd_go}, 32'h0);
        rst = 1'b0;
        read_open(8'h02);
        chk("R1 R2 status after reset", bus_rdata, 32'h0);
        read_close();
        read_open(8'h10);
        chk("R1 R9 mgmt word after reset", bus_rdata, 32'h1000_0000);
        read_close();

        // status / interrupt table: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            logic [21:0] v;
            v = VEC[i];
            bus_write(8'h00, {31'b0, v[21]});
            @(negedge clk);
            stat_event = v[20:17]; bus_wr = 1'b1; bus_addr = 8'h02;
            bus_wdata = {16'b0, v[16:9], 8'h00};
            @(negedge clk);
            stat_event = '0; bus_wr = 1'b0;
            bus_rd = 1'b1; bus_addr = 8'h02;
            #2;
            chk($sformatf("R2 R3 R4 status vector %0d", i), bus_rdata, {16'b0, v[8:1], 8'h00});
            chk($sformatf("R5 irq vector %0d", i), {31'b0, irq}, {31'b0, v[0]});
            read_close();
        end

        read_open(8'h00);
        chk("R5 interrupt-control reads zero", bus_rdata, 32'h0);
        read_close();

        // general pointer: R7
        bus_write(8'h04, 32'hDEAD_BEEF);
        chk("R7 gptr port", gptr, 32'hDEAD_BEEF);
        read_open(8'h04);
        chk("R7 gptr readback", bus_rdata, 32'hDEAD_BEEF);
        read_close();

        // command dispatch: R6
        bus_write(8'h01, 32'h0000_0052);
        chk("R6 cu first", {26'b0, cu_go, cu_op, ru_go}, {26'b0, 1'b1, 4'd5, 1'b0});
        @(negedge clk); #1;
        chk("R6 ru second", {27'b0, cu_go, ru_go, ru_op}, {27'b0, 1'b0, 1'b1, 3'd2});
        bus_write(8'h01, 32'h0000_0030);
        chk("R6 cu only", {27'b0, cu_go, cu_op}, {27'b0, 1'b1, 4'd3});
        @(negedge clk); #1;
        chk("R6 ru no-op silent", {31'b0, ru_go}, 32'h0);
        bus_write(8'h01, 32'h0000_0007);
        chk("R6 cu no-op silent", {31'b0, cu_go}, 32'h0);
        @(negedge clk); #1;
        chk("R6 ru only", {28'b0, ru_go, ru_op}, {28'b0, 1'b1, 3'd7});

        // management: R8 R9
        bus_write(8'h10, 32'h0469_A5C3);
        chk("R8 write trigger", {31'b0, mgmt_wr_go}, 32'h1);
        chk("R8 write fields", {6'b0, mgmt_phy, mgmt_reg, mgmt_wdata}, {6'b0, 5'd3, 5'd9, 16'hA5C3});
        @(negedge clk); #1;
        chk("R8 trigger one cycle", {31'b0, mgmt_wr_go}, 32'h0);
        bus_write(8'h10, 32'h0800_0000);
        chk("R8 read opcode no write trigger", {31'b0, mgmt_wr_go}, 32'h0);
        phy_rdata = 16'h1234;
        read_open(8'h10);
        chk("R9 read returns PHY data", bus_rdata, 32'h1800_1234);
        chk("R9 read trigger", {31'b0, mgmt_rd_go}, 32'h1);
        read_close();
        phy_rdata = 16'h0000;
        #1;
        chk("R9 data captured", {16'b0, mgmt_wdata}, 32'h0000_1234);
        bus_write(8'h10, 32'h0000_00FF);
        read_open(8'h10);
        chk("R9 idle opcode no trigger", {31'b0, mgmt_rd_go}, 32'h0);
        chk("R9 ready bit on idle read", bus_rdata, 32'h1000_00FF);
        read_close();

        // unknown offsets: R10
        @(negedge clk);
        stat_event = 4'b1000;
        @(negedge clk);
        stat_event = '0;
        bus_write(8'h03, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h05, 32'h0000_0000);
        read_open(8'h08);
        chk("R10 unknown reads zero", bus_rdata, 32'h0);
        read_close();
        read_open(8'h02);
        chk("R10 status untouched", bus_rdata, 32'h0000_8000);
        read_close();
        read_open(8'h04);
        chk("R10 gptr untouched", bus_rdata, 32'hDEAD_BEEF);
        read_close();
        chk("R10 irq still raised", {31'b0, irq}, 32'h1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule